// File: doc/BRIEF.md
# Sixteen-Point Constant Twiddle Multiplier

This block rotates one fixed-point complex sample per clock by a selectable power of the sixteen-point unit root, W^k = e^(-j*pi*k/8) with k from 0 to 7. It sits between the butterfly stages of a pipelined transform. The arithmetic is built only from hard-wired shift-and-add constant products, so no general multiplier array is needed.

The selector chooses one of four rotation classes and, separately, an optional minus-j quarter turn. The quarter turn is a swap of the real and imaginary parts with one negation and uses no multiplier. The identity needs no arithmetic. The eighth turn (k = 2) needs two constant products. The odd sixteenth turns (k = 1 and k = 3) share one three-product datapath. It uses one common product on the sum of the two parts and two products by cos+sin and cos-sin, and only the operand routing and one output sign differ between the two. Selectors 4 to 7 apply the quarter turn first and then reuse the rotations for 0 to 3.

Every selector has the same two-cycle latency. Results are rounded to nearest and saturated to the input width.

Top module: `twid16_cmul`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly two clock cycles earlier, for every selector value, with or without idle gaps between samples.
- R2: Selector 0 returns the input sample unchanged, bit for bit.
- R3: Selector 4 (minus j) returns real = input imaginary and imaginary = negated input real, exactly. A negated -32768 becomes +32767.
- R4: Selector 2 returns the rotation by e^(-j*pi/4) within 2 LSB of the ideal rounded value. An input with equal real and imaginary parts yields an imaginary result of exactly 0.
- R5: Selectors 1 and 3 return the rotation by e^(-j*pi/8) and e^(-j*3pi/8) within 2 LSB of the ideal rounded value.
- R6: Selectors 5, 6 and 7 return the rotation by e^(-j*pi*k/8) within 2 LSB of the ideal rounded value.
- R7: A result part whose ideal value lies above 32767 or below -32768 is clamped to exactly 32767 or -32768.
- R8: While `out_valid` is low, `out_re` and `out_im` keep their previous values.
- R9: While reset is asserted, `out_valid` is 0 and both result parts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 16 | Input real part, two's complement |
| in_im | input | 16 | Input imaginary part, two's complement |
| in_sel | input | 3 | Twiddle power k, rotation by e^(-j*pi*k/8) |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_re | output | 16 | Result real part, rounded and saturated |
| out_im | output | 16 | Result imaginary part, rounded and saturated |

## Verification
The minus-j quarter turn and the saturating constant rotation act on the same sample whenever the selector is 5, 6 or 7. The pre-rotation is applied in the first stage and the clamp in the second. The bench provokes this with full-scale and most-negative inputs under those selectors, placed back to back with samples of other selectors so that both pipeline stages hold different rotation classes at once. Each result is judged against a real-valued rotation of the original sample, rounded and clamped in the bench. Clamped parts must match exactly, and the others must lie within 2 LSB.

// File: rtl/twid_pkg.sv
package twid_pkg;

  // Rotation class applied after the optional quarter turn.
  typedef enum logic [1:0] {
    ROT_UNIT = 2'd0,
    ROT_P1   = 2'd1,
    ROT_P2   = 2'd2,
    ROT_P3   = 2'd3
  } rot_e;

  function automatic rot_e rot_of_sel(input logic [2:0] sel);
    return rot_e'(sel[1:0]);
  endfunction

  function automatic logic quarter_of_sel(input logic [2:0] sel);
    return sel[2];
  endfunction

endpackage

// File: rtl/twid_prerot.sv
module twid_prerot
  import twid_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [2:0]           in_sel,
  output logic                 s1_valid,
  output logic signed [IW-1:0] s1_a,
  output logic signed [IW-1:0] s1_b,
  output rot_e                 s1_rot
);

  logic                 quarter_turn;
  logic signed [IW-1:0] re_x;
  logic signed [IW-1:0] im_x;
  logic signed [IW-1:0] a_nx;
  logic signed [IW-1:0] b_nx;

  assign quarter_turn = quarter_of_sel(in_sel);
  assign re_x = IW'(in_re);
  assign im_x = IW'(in_im);
  // (a + jb)(-j) = b - ja, kept in guard width so -(-32768) does not wrap
  assign a_nx = quarter_turn ? im_x  : re_x;
  assign b_nx = quarter_turn ? -re_x : im_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_rot   <= ROT_UNIT;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_a   <= a_nx;
        s1_b   <= b_nx;
        s1_rot <= rot_of_sel(in_sel);
      end
    end
  end

endmodule

// File: rtl/twid_cmul.sv
module twid_cmul
  import twid_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IW    = 19,
  parameter int CFRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  input  logic signed [IW-1:0] s1_a,
  input  logic signed [IW-1:0] s1_b,
  input  rot_e                 s1_rot,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam int CW = CFRAC + 2;
  localparam int PW = IW + CW;
  localparam int SH = 30 - CFRAC;

  // cos(pi/8), sin(pi/8), cos(pi/4) scaled by 2^30, then rounded to CFRAC bits
  localparam longint C30 = 64'sd992008094;
  localparam longint S30 = 64'sd410903207;
  localparam longint R30 = 64'sd759250125;
  localparam longint RND = 64'sd1 <<< (SH - 1);
  localparam int K_C   = int'((C30 + RND) >>> SH);
  localparam int K_CPS = int'((C30 + S30 + RND) >>> SH);
  localparam int K_CMS = int'((C30 - S30 + RND) >>> SH);
  localparam int K_R2  = int'((R30 + RND) >>> SH);

  localparam logic signed [PW-1:0] HALF =
    {{(PW-CFRAC){1'b0}}, 1'b1, {(CFRAC-1){1'b0}}};
  localparam logic signed [PW-1:0] SAT_HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] SAT_LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // Constant product by signed-digit recoding: each nonzero digit is one shifted add or subtract.
  function automatic logic signed [PW-1:0] cmul_k(input logic signed [IW-1:0] x,
                                                  input int k);
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] acc;
    int r;
    xe  = PW'(x);
    acc = '0;
    r   = k;
    for (int i = 0; i <= CW; i++) begin
      if ((r & 3) == 1) begin
        acc = acc + (xe <<< i);
        r   = r - 1;
      end else if ((r & 3) == 3) begin
        acc = acc - (xe <<< i);
        r   = r + 1;
      end
      r = r >>> 1;
    end
    return acc;
  endfunction

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] t;
    t = (v + HALF) >>> CFRAC;
    if (t > SAT_HI) return SAT_HI[DW-1:0];
    if (t < SAT_LO) return SAT_LO[DW-1:0];
    return t[DW-1:0];
  endfunction

  logic                 odd_swap;
  logic signed [IW-1:0] sum_ab;
  logic signed [IW-1:0] dif_ba;
  logic signed [IW-1:0] op_u;
  logic signed [IW-1:0] op_v;
  logic signed [PW-1:0] m_c;
  logic signed [PW-1:0] m_u;
  logic signed [PW-1:0] m_v;
  logic signed [PW-1:0] m_r2a;
  logic signed [PW-1:0] m_r2b;
  logic signed [PW-1:0] pr;
  logic signed [PW-1:0] pi;
  logic signed [DW-1:0] res_re;
  logic signed [DW-1:0] res_im;

  // W^1 and W^3 share the three constants; only operand routing and one sign differ
  assign odd_swap = (s1_rot == ROT_P1);
  assign sum_ab   = s1_a + s1_b;
  assign dif_ba   = s1_b - s1_a;
  assign op_u     = odd_swap ? s1_b : s1_a;
  assign op_v     = odd_swap ? s1_a : s1_b;
  assign m_c      = cmul_k(sum_ab, K_C);
  assign m_u      = cmul_k(op_u, K_CMS);
  assign m_v      = cmul_k(op_v, K_CPS);
  assign m_r2a    = cmul_k(sum_ab, K_R2);
  assign m_r2b    = cmul_k(dif_ba, K_R2);

  always_comb begin
    case (s1_rot)
      ROT_P1: begin
        pr = m_c - m_u;
        pi = m_c - m_v;
      end
      ROT_P3: begin
        pr = m_c - m_u;
        pi = m_v - m_c;
      end
      ROT_P2: begin
        pr = m_r2a;
        pi = m_r2b;
      end
      default: begin
        pr = PW'(s1_a) <<< CFRAC;
        pi = PW'(s1_b) <<< CFRAC;
      end
    endcase
  end

  assign res_re = rnd_sat(pr);
  assign res_im = rnd_sat(pi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_re <= res_re;
        out_im <= res_im;
      end
    end
  end

  // R8: idle cycles leave the result registers untouched
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_re) && $stable(out_im)));

endmodule

// File: rtl/twid16_cmul.sv
module twid16_cmul
  import twid_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 3,
  parameter int CFRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [2:0]           in_sel,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam int IW = DW + GUARD;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic                 s1_valid;
  logic signed [IW-1:0] s1_a;
  logic signed [IW-1:0] s1_b;
  rot_e                 s1_rot;

  twid_prerot #(.DW(DW), .IW(IW)) u_prerot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_re    (in_re),
    .in_im    (in_im),
    .in_sel   (in_sel),
    .s1_valid (s1_valid),
    .s1_a     (s1_a),
    .s1_b     (s1_b),
    .s1_rot   (s1_rot)
  );

  twid_cmul #(.DW(DW), .IW(IW), .CFRAC(CFRAC)) u_cmul (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_a      (s1_a),
    .s1_b      (s1_b),
    .s1_rot    (s1_rot),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  // R1: fixed two-cycle latency of the strobe
  p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R2: identity selector is bit exact
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == 3'd0) |-> ##2
      (out_re == $past(in_re, 2) && out_im == $past(in_im, 2)));

  // R3: minus-j swap with a saturated negation of the most negative value
  p_negj_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == 3'd4) |-> ##2
      (out_re == $past(in_im, 2) &&
       out_im == (($past(in_re, 2) == MINV) ? MAXV : -$past(in_re, 2))));

  // R4: equal parts under the eighth turn give a zero imaginary part
  p_eighth_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == 3'd2 && in_re == in_im) |-> ##2 (out_im == '0));

endmodule

// File: tb/twid16_cmul_tb.sv
module twid16_cmul_tb;

  localparam int DW = 16;
  localparam real PI_R = 3.14159265358979323846;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic [2:0]           in_sel = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_re;
  logic signed [DW-1:0] out_im;

  always #4 clk = ~clk;

  twid16_cmul u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_re     (in_re),
    .in_im     (in_im),
    .in_sel    (in_sel),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  int n_chk = 0;
  int n_bad = 0;
  int qs[$];
  int qa[$];
  int qb[$];
  bit vh0 = 1'b0;
  bit vh1 = 1'b0;
  int last_re = 0;
  int last_im = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real ideal(input int s, input int a, input int b, input bit imag);
    real ang;
    ang = PI_R * s / 8.0;
    if (imag) return b * $cos(ang) - a * $sin(ang);
    return a * $cos(ang) + b * $sin(ang);
  endfunction

  function automatic int quant(input real x);
    int e;
    e = $rtoi($floor(x + 0.5));
    if (e > 32767) e = 32767;
    if (e < -32768) e = -32768;
    return e;
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0: return "R2";
      4: return "R3";
      2: return "R4";
      1, 3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic judge(input int s, input int a, input int b, input bit imag, input int act);
    real x;
    int e, tol, d;
    string nm;
    x   = ideal(s, a, b, imag);
    e   = quant(x);
    tol = (s == 0 || s == 4) ? 0 : 2;
    nm  = imag ? "out_im" : "out_re";
    if (x > 32770.0 || x < -32771.0) begin
      chk(act == e, "R7", nm, act, e);
    end else if (s == 2 && imag && a == b) begin
      chk(act == 0, "R4", nm, act, 0);
    end else begin
      d = act - e;
      chk(d <= tol && d >= -tol, req_of(s), nm, act, e);
    end
  endtask

  task automatic step(input bit v, input int s, input int a, input int b);
    int ps, pa, pb;
    @(negedge clk);
    chk(out_valid == vh1, "R1", "out_valid", int'(out_valid), int'(vh1));
    if (vh1) begin
      ps = qs.pop_front();
      pa = qa.pop_front();
      pb = qb.pop_front();
      judge(ps, pa, pb, 1'b0, int'(out_re));
      judge(ps, pa, pb, 1'b1, int'(out_im));
    end else begin
      chk(int'(out_re) == last_re, "R8", "out_re hold", int'(out_re), last_re);
      chk(int'(out_im) == last_im, "R8", "out_im hold", int'(out_im), last_im);
    end
    last_re = int'(out_re);
    last_im = int'(out_im);
    vh1 = vh0;
    vh0 = v;
    in_valid = v;
    in_sel   = 3'(s);
    in_re    = DW'(a);
    in_im    = DW'(b);
    if (v) begin
      qs.push_back(s);
      qa.push_back(a);
      qb.push_back(b);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    chk(out_re == '0, "R9", "out_re in reset", int'(out_re), 0);
    chk(out_im == '0, "R9", "out_im in reset", int'(out_im), 0);
    rst_n = 1'b1;

    // every selector on a moderate sample
    for (int s = 0; s < 8; s++) step(1'b1, s, 12345, -6789);
    step(1'b0, 0, 0, 0);
    // R3: negation of the most negative value
    step(1'b1, 4, -32768, 1234);
    // R4: equal parts give a zero imaginary part
    step(1'b1, 2, 1000, 1000);
    step(1'b1, 6, -2000, -2000);
    // R7: saturation under odd rotations, with and without the quarter turn
    step(1'b1, 1, 32767, 32767);
    step(1'b1, 5, -32768, -32768);
    step(1'b1, 3, -32768, 32767);
    step(1'b1, 7, 32767, -32768);
    step(1'b1, 6, 32767, -32768);
    step(1'b1, 0, -32768, 32767);
    step(1'b0, 3, 5, 5);
    step(1'b0, 1, 7, 7);
    // alternating classes, back to back
    for (int i = 0; i < 64; i++)
      step(1'b1, (i * 5) % 8, (i * 1031) % 65536 - 32768, 32767 - (i * 977) % 65536);
    // random stream with gaps
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 7),
           $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768);
    end
    step(1'b0, 0, 0, 0);
    step(1'b0, 0, 0, 0);
    step(1'b0, 0, 0, 0);
    summary();
  end

endmodule